// File: doc/BRIEF.md
# Synchronous Binary Counter with Parallel Load and Dual Count Enables

This block is a small binary up-counter, four bits wide by default, whose state changes only on the rising clock edge. A synchronous active-low clear forces the count to zero, and a synchronous active-low load copies a parallel input word into the count. Two count-enable inputs gate the increment. The count advances by one only when both enables are high.

A terminal-carry output goes high while the count is at its all-ones value and the second enable is high. That output can drive the second enable of a further stage. Several instances then form one wider counter in which all stages share a clock. The upper stage steps only on the edge where the lower stage rolls over.

Top module: `sync_counter`

## Requirements
- R1: When `clearN` is low at a rising edge, `count` becomes 0 after that edge, whatever `loadN`, `enA`, `enB` and `loadVal` are.
- R2: When `clearN` is high and `loadN` is low at a rising edge, `count` takes the value of `loadVal` after that edge, even if one or both enables are low.
- R3: When `clearN` and `loadN` are high and both `enA` and `enB` are high at a rising edge, `count` becomes its previous value plus one.
- R4: When `clearN` and `loadN` are high and either enable is low at a rising edge, `count` is unchanged.
- R5: Counting from the all-ones value (15 at the default width) wraps `count` to 0.
- R6: `carryOut` is 1 exactly when `count` is all ones and `enB` is 1. It follows `enB` combinationally and does not depend on `enA`.
- R7: Two stages, with the upper stage's `enB` driven by the lower stage's `carryOut`, form an 8-bit counter that steps through 0 to 255 in order. The upper stage changes only on the edge where the lower stage wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change is on its rising edge |
| clearN | input | 1 | Synchronous clear, active low, highest priority |
| loadN | input | 1 | Synchronous parallel load, active low |
| enA | input | 1 | Count enable that gates counting only |
| enB | input | 1 | Count enable that also gates `carryOut` |
| loadVal | input | WIDTH | Parallel data taken on a load |
| count | output | WIDTH | Present count value |
| carryOut | output | 1 | Terminal carry: all-ones count AND `enB` |

## Verification
The assertions check the per-edge update rule on every cycle: clear to zero, load of the sampled word, increment by one, hold, and wrap from all ones to zero. A further assertion checks that no two update strobes are active at once. The order of priority among clear, load and count, and the masking of the carry by `enB`, are shown by bench vectors that apply conflicting controls together. The scenarios alone demonstrate the two-stage cascade. They run it through a full 256-state cycle and check that the upper nibble moves only at the lower nibble's rollover.

// File: rtl/sync_counter_pkg.sv
package sync_counter_pkg;
  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic clr;
    logic ld;
    logic inc;
  } cnt_strobe_t;
endpackage

// File: rtl/sync_counter_ctrl.sv
module sync_counter_ctrl
  import sync_counter_pkg::*;
(
  input  logic        clearN,
  input  logic        loadN,
  input  logic        enA,
  input  logic        enB,
  input  logic        atTerminal,
  output cnt_strobe_t strobes,
  output logic        carryOut
);
  logic bothEn;

  assign bothEn = enA & enB;

  // Priority: clear, then load, then count.
  always_comb begin
    strobes     = '0;
    if (!clearN) begin
      strobes.clr = 1'b1;
    end else if (!loadN) begin
      strobes.ld  = 1'b1;
    end else if (bothEn) begin
      strobes.inc = 1'b1;
    end
  end

  // R6: the carry is gated by the second enable only
  assign carryOut = atTerminal & enB;

  // R1 R2 priority keeps the update strobes exclusive
  always_comb begin
    strobe_excl_chk: assert ($onehot0(strobes))
      else $error("update strobes overlap");
  end
endmodule

// File: rtl/sync_counter_dp.sv
module sync_counter_dp
  import sync_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  cnt_strobe_t      strobes,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] count,
  output logic             atTerminal
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

  logic [WIDTH-1:0] incVal;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] nextCount;

  // Half-adder ripple that adds one.
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_inc
    assign incVal[i]   = count[i] ^ chain[i];
    assign chain[i+1]  = count[i] & chain[i];
  end

  always_comb begin
    nextCount = count;
    if (strobes.clr)      nextCount = '0;
    else if (strobes.ld)  nextCount = loadVal;
    else if (strobes.inc) nextCount = incVal;
  end

  always_ff @(posedge clk) begin
    count <= nextCount;
  end

  assign atTerminal = (count == MAX_VAL);

  // R1
  clr_zero_chk: assert property (@(posedge clk)
    strobes.clr |=> count == '0)
    else $error("clear did not zero the count");

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (strobes.clr)
    strobes.ld |=> count == $past(loadVal))
    else $error("load value not taken");

  // R3
  step_chk: assert property (@(posedge clk) disable iff (strobes.clr)
    strobes.inc |=> count == WIDTH'($past(count) + 1'b1))
    else $error("count did not advance by one");

  // R4
  hold_chk: assert property (@(posedge clk)
    !(strobes.clr | strobes.ld | strobes.inc) |=> $stable(count))
    else $error("count moved while idle");
endmodule

// File: rtl/sync_counter.sv
module sync_counter
  import sync_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             enA,
  input  logic             enB,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);
  cnt_strobe_t strobes;
  logic        atTerminal;

  sync_counter_ctrl u_ctrl (
    .clearN     (clearN),
    .loadN      (loadN),
    .enA        (enA),
    .enB        (enB),
    .atTerminal (atTerminal),
    .strobes    (strobes),
    .carryOut   (carryOut)
  );

  sync_counter_dp #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .strobes    (strobes),
    .loadVal    (loadVal),
    .count      (count),
    .atTerminal (atTerminal)
  );

  // R5: a counting edge taken with carry high wraps to zero
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!clearN || !loadN)
    (carryOut && enA) |=> count == '0)
    else $error("no wrap from the terminal value");
endmodule

// File: tb/sync_counter_bench.sv
module sync_counter_bench;
  logic       clk = 1'b0;
  logic       clearN, loadN, enA, enB;
  logic [3:0] loadVal;
  logic [3:0] count;
  logic       carryOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sync_counter #(.WIDTH(4)) u_sync_counter (
    .clk(clk), .clearN(clearN), .loadN(loadN), .enA(enA), .enB(enB),
    .loadVal(loadVal), .count(count), .carryOut(carryOut)
  );

  // Two-stage cascade
  logic       cClr, cLd;
  logic [3:0] loVal, hiVal, loCnt, hiCnt;
  logic       loCarry, hiCarry;

  sync_counter #(.WIDTH(4)) u_lo (
    .clk(clk), .clearN(cClr), .loadN(cLd), .enA(1'b1), .enB(1'b1),
    .loadVal(loVal), .count(loCnt), .carryOut(loCarry)
  );
  sync_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .clearN(cClr), .loadN(cLd), .enA(1'b1), .enB(loCarry),
    .loadVal(hiVal), .count(hiCnt), .carryOut(hiCarry)
  );

  // {clearN, loadN, enA, enB, loadVal[3:0], expCount[3:0], expCarry}
  localparam int NVEC = 16;
  localparam logic [12:0] VECS [NVEC] = '{
    {4'b0111, 4'd5,  4'd0,  1'b0},  // R1 clear with enables high
    {4'b1111, 4'd0,  4'd1,  1'b0},  // R3
    {4'b1111, 4'd0,  4'd2,  1'b0},  // R3
    {4'b1101, 4'd0,  4'd2,  1'b0},  // R4 enA low
    {4'b1110, 4'd0,  4'd2,  1'b0},  // R4 enB low
    {4'b1000, 4'd13, 4'd13, 1'b0},  // R2 load with enables low
    {4'b1111, 4'd0,  4'd14, 1'b0},  // R3
    {4'b1111, 4'd0,  4'd15, 1'b1},  // R6 carry at terminal
    {4'b1110, 4'd0,  4'd15, 1'b0},  // R6 enB masks carry, R4 hold
    {4'b1101, 4'd0,  4'd15, 1'b1},  // R6 enA has no effect on carry
    {4'b1111, 4'd0,  4'd0,  1'b0},  // R5 wrap
    {4'b1011, 4'd9,  4'd9,  1'b0},  // R2 load beats count
    {4'b0011, 4'd3,  4'd0,  1'b0},  // R1 clear beats load
    {4'b1011, 4'd15, 4'd15, 1'b1},  // R2 load to terminal, R6
    {4'b1111, 4'd0,  4'd0,  1'b0},  // R5 wrap
    {4'b1111, 4'd0,  4'd1,  1'b0}   // R3
  };

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int expWide;
    logic [3:0] prevLo, prevHi;
    clearN = 1'b0; loadN = 1'b1; enA = 1'b0; enB = 1'b0; loadVal = '0;
    cClr = 1'b0; cLd = 1'b1; loVal = '0; hiVal = '0;

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      {clearN, loadN, enA, enB, loadVal} = VECS[i][12:5];
      @(negedge clk);
      check($sformatf("R1-R6 vector %0d count", i), count, VECS[i][4:1]);
      check($sformatf("R6 vector %0d carry", i), carryOut, VECS[i][0]);
    end

    // R6 combinational: carry follows enB without an edge
    clearN = 1'b1; loadN = 1'b0; loadVal = 4'd15; enA = 1'b0; enB = 1'b0;
    @(negedge clk);
    check("R2 load to 15", count, 15);
    loadN = 1'b1; enB = 1'b1;
    #1;
    check("R6 carry rises with enB", carryOut, 1);
    enB = 1'b0;
    #1;
    check("R6 carry falls with enB", carryOut, 0);

    // R7 cascade: clear then a full cycle plus margin
    @(negedge clk);
    check("R7 cascade cleared", {hiCnt, loCnt}, 0);
    cClr = 1'b1;
    expWide = 0;
    for (int k = 0; k < 260; k++) begin
      prevLo = loCnt; prevHi = hiCnt;
      @(negedge clk);
      expWide = (expWide + 1) % 256;
      check("R7 cascade value", {hiCnt, loCnt}, expWide);
      if (prevLo != 4'd15)
        check("R7 upper holds off wrap", hiCnt, prevHi);
    end

    // R7 cascade wrap through 255
    cLd = 1'b0; hiVal = 4'hF; loVal = 4'hE;
    @(negedge clk);
    cLd = 1'b1;
    check("R7 cascade load", {hiCnt, loCnt}, 8'hFE);
    @(negedge clk);
    check("R7 cascade at 255", {hiCnt, loCnt}, 8'hFF);
    check("R7 upper carry at 255", hiCarry, 1);
    @(negedge clk);
    check("R7 cascade wraps", {hiCnt, loCnt}, 0);
    check("R7 upper carry after wrap", hiCarry, 0);

    summary();
  end
endmodule